// File: doc/BRIEF.md
# ADC Conversion Clock Generator

This block produces the conversion clock enable for an analog-to-digital converter core. A 2-bit select field picks one of four sources, and a 2-bit divide field then divides the chosen source by 1, 2, 4 or 8. Each source is presented as a per-cycle tick in the block's single clock domain, and the result is a one-cycle `adcTickEn` pulse rather than a derived clock. The sources are the bus clock, the bus clock halved, an alternate tick, and the tick of a local asynchronous oscillator.

The block also decides when the local oscillator runs. With the keep-alive bit set, the oscillator is requested all the time. Without it, and with the oscillator source selected, the request is raised by a conversion start and dropped by a conversion terminate. Each time the request rises, a startup counter clocked by oscillator ticks must expire before `oscReady` goes high. Until then a conversion start is held pending and released as a one-cycle `convGo` pulse. Register fields arrive as plain inputs.

Top module: `adc_clk_gen`

## Requirements
- R1: Select encoding 00 gives one source tick per clock cycle, 01 gives one every second cycle, 10 gives one per cycle in which `altTick` is high, and 11 gives one per cycle in which `oscTick` is high while `oscReady` is high.
- R2: Divide encoding 00, 01, 10 and 11 emits one `adcTickEn` pulse per 1, 2, 4 and 8 source ticks. With a divide above 1, two pulses are never in consecutive cycles.
- R3: Select 01 combined with divide 11 yields exactly one `adcTickEn` pulse every 16 clock cycles.
- R4: Any change of the select or divide field restarts the divider. With select 00 and divide 11, the first pulse after a change appears in the 8th cycle after the clock edge that sees the new value.
- R5: While `oscEnable` is 1, `oscReq` is high regardless of conversion start or terminate.
- R6: With select 11 and `oscEnable` 0, `oscReq` goes high the cycle after `convStart` and goes low the cycle after `convDone`.
- R7: `oscReady` rises after exactly `STARTUP_TICKS` (default 8) oscillator ticks are seen with `oscReq` high. It is low one cycle after `oscReq` is seen low.
- R8: `convGo` is a one-cycle pulse. For select 00, 01 or 10 it appears the cycle after `convStart`. For select 11 it is held back until `oscReady` is high and appears in the first cycle in which `oscReady` is seen high.
- R9: With select 11 and `oscReady` low, no `adcTickEn` pulse is produced.
- R10: During and right after reset, `oscReq`, `oscReady` and `convGo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (bus clock) |
| rstN | input | 1 | Active-low asynchronous reset |
| selField | input | 2 | Source select: 00 bus, 01 bus/2, 10 alternate, 11 local oscillator |
| divField | input | DIV_W | Divide select: divides by 2**divField |
| oscEnable | input | 1 | Keep the local oscillator requested permanently |
| convStart | input | 1 | One-cycle conversion start request |
| convDone | input | 1 | One-cycle conversion terminate |
| altTick | input | 1 | Alternate source tick |
| oscTick | input | 1 | Local oscillator tick |
| oscReq | output | 1 | Oscillator run request |
| oscReady | output | 1 | Oscillator startup delay has elapsed |
| convGo | output | 1 | One-cycle conversion release |
| adcTickEn | output | 1 | One-cycle conversion clock enable |

## Verification
The assertions assume that `convStart` and `convDone` are single-cycle pulses that never coincide. They also assume that no new start arrives while an earlier one is still pending. The stimulus follows these rules: it raises each pulse for exactly one cycle and always waits for `convGo` before raising the next start. Field changes are made only between measurement windows. The oscillator and alternate ticks come from a free-running phase register updated on the clock edge, so every tick is a clean single-cycle level.

// File: rtl/adc_clk_pkg.sv
package adc_clk_pkg;
  localparam logic [1:0] SEL_BUS  = 2'b00;
  localparam logic [1:0] SEL_HALF = 2'b01;
  localparam logic [1:0] SEL_ALT  = 2'b10;
  localparam logic [1:0] SEL_OSC  = 2'b11;

  typedef struct packed {
    logic cfgClear;  // select or divide field changed this cycle
    logic oscReq;    // oscillator requested
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_clk_datapath.sv
module adc_clk_datapath
  import adc_clk_pkg::*;
#(
  parameter int DIV_W         = 2,
  parameter int STARTUP_TICKS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       selField,
  input  logic [DIV_W-1:0] divField,
  input  logic             altTick,
  input  logic             oscTick,
  input  ctrlStrobes_t     strobes,
  output logic             adcTickEn,
  output logic             oscReady
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int ST_W  = $clog2(STARTUP_TICKS + 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STARTUP_TICKS - 1);

  logic             halfPhase;
  logic             srcTick;
  logic [CNT_W:0]   divSpan;
  logic [CNT_W:0]   divSpanM1;
  logic [CNT_W-1:0] divMax;
  logic [CNT_W-1:0] divCnt;
  logic [ST_W-1:0]  stCnt;

  // bus clock halved: phase toggles every cycle, realigned on a field change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 halfPhase <= 1'b0;
    else if (strobes.cfgClear) halfPhase <= 1'b0;
    else                       halfPhase <= ~halfPhase;
  end

  always_comb begin
    unique case (selField)
      SEL_BUS:  srcTick = 1'b1;
      SEL_HALF: srcTick = halfPhase;
      SEL_ALT:  srcTick = altTick;
      default:  srcTick = oscTick & oscReady;
    endcase
  end

  assign divSpan   = (CNT_W + 1)'(1) << divField;
  assign divSpanM1 = divSpan - 1'b1;
  assign divMax    = divSpanM1[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (strobes.cfgClear) divCnt <= '0;
    else if (srcTick) begin
      if (divCnt == divMax) divCnt <= '0;
      else                  divCnt <= divCnt + 1'b1;
    end
  end

  assign adcTickEn = srcTick && (divCnt == divMax) && !strobes.cfgClear;

  // startup delay counted in oscillator ticks while requested
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stCnt    <= '0;
      oscReady <= 1'b0;
    end else if (!strobes.oscReq) begin
      stCnt    <= '0;
      oscReady <= 1'b0;
    end else if (!oscReady && oscTick) begin
      if (stCnt == ST_LAST) oscReady <= 1'b1;
      else                  stCnt    <= stCnt + 1'b1;
    end
  end

  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.oscReq |=> !oscReady);

  assert_no_async_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (selField == SEL_OSC && !oscReady) |-> !adcTickEn);

  assert_pulse_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (adcTickEn && divField != '0) |=> !adcTickEn);
endmodule

// File: rtl/adc_clk_control.sv
module adc_clk_control
  import adc_clk_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       selField,
  input  logic [DIV_W-1:0] divField,
  input  logic             oscEnable,
  input  logic             convStart,
  input  logic             convDone,
  input  logic             oscReady,
  output ctrlStrobes_t     strobes,
  output logic             convGo
);
  localparam int KEY_W = 2 + DIV_W;

  logic [KEY_W-1:0] prevKey;
  logic             convActive;
  logic             goPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevKey <= '0;
    else       prevKey <= {selField, divField};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   convActive <= 1'b0;
    else if (convDone)                           convActive <= 1'b0;
    else if (convStart && selField == SEL_OSC)   convActive <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          goPending <= 1'b0;
    else if (convGo)    goPending <= 1'b0;
    else if (convStart) goPending <= 1'b1;
  end

  assign convGo           = goPending && (selField != SEL_OSC || oscReady);
  assign strobes.cfgClear = ({selField, divField} != prevKey);
  assign strobes.oscReq   = oscEnable | convActive;

  assert_go_needs_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (convGo && selField == SEL_OSC) |-> oscReady);

  assert_go_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (convGo && !convStart) |=> !convGo);

  assert_done_drops_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !oscEnable && !convStart) |=> !strobes.oscReq);
endmodule

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
  import adc_clk_pkg::*;
#(
  parameter int DIV_W         = 2,
  parameter int STARTUP_TICKS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       selField,
  input  logic [DIV_W-1:0] divField,
  input  logic             oscEnable,
  input  logic             convStart,
  input  logic             convDone,
  input  logic             altTick,
  input  logic             oscTick,
  output logic             oscReq,
  output logic             oscReady,
  output logic             convGo,
  output logic             adcTickEn
);
  ctrlStrobes_t strobes;

  adc_clk_control #(.DIV_W(DIV_W)) control_i (
    .clk(clk), .rstN(rstN), .selField(selField), .divField(divField),
    .oscEnable(oscEnable), .convStart(convStart), .convDone(convDone),
    .oscReady(oscReady), .strobes(strobes), .convGo(convGo)
  );

  adc_clk_datapath #(.DIV_W(DIV_W), .STARTUP_TICKS(STARTUP_TICKS)) datapath_i (
    .clk(clk), .rstN(rstN), .selField(selField), .divField(divField),
    .altTick(altTick), .oscTick(oscTick), .strobes(strobes),
    .adcTickEn(adcTickEn), .oscReady(oscReady)
  );

  assign oscReq = strobes.oscReq;

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (!oscReady && !convGo));
endmodule

// File: tb/adc_clk_gen_tb.sv
`timescale 1ns/1ps
module adc_clk_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] selField = 2'b00;
  logic [1:0] divField = 2'b00;
  logic oscEnable = 1'b0, convStart = 1'b0, convDone = 1'b0;
  logic phase = 1'b0;
  logic altTick, oscTick;
  logic oscReq, oscReady, convGo, adcTickEn;
  int checkCount = 0, failCount = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) phase <= ~phase;
  assign altTick = phase;
  assign oscTick = phase;

  adc_clk_gen dut_i (
    .clk(clk), .rstN(rstN), .selField(selField), .divField(divField),
    .oscEnable(oscEnable), .convStart(convStart), .convDone(convDone),
    .altTick(altTick), .oscTick(oscTick), .oscReq(oscReq),
    .oscReady(oscReady), .convGo(convGo), .adcTickEn(adcTickEn)
  );

  // {sel, div, expected pulses in 128 cycles}
  localparam int NVEC = 8;
  localparam logic [11:0] VECS [NVEC] = '{
    {2'b00, 2'b00, 8'd128}, {2'b00, 2'b01, 8'd64}, {2'b00, 2'b10, 8'd32},
    {2'b00, 2'b11, 8'd16},  {2'b01, 2'b00, 8'd64}, {2'b01, 2'b11, 8'd8},
    {2'b10, 2'b00, 8'd64},  {2'b10, 2'b10, 8'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic countWin(output int n);
    n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (adcTickEn) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    int n, first, ticks;
    bit goSeen;
    repeat (3) @(negedge clk);
    check(!oscReq && !oscReady && !convGo, "R10 in reset", {oscReq, oscReady, convGo}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!oscReq && !oscReady && !convGo, "R10 after reset", {oscReq, oscReady, convGo}, 0);

    // R1 R2 R3: source and divide table
    for (int v = 0; v < NVEC; v++) begin
      selField = VECS[v][11:10];
      divField = VECS[v][9:8];
      countWin(n);
      check(n == int'(VECS[v][7:0]), $sformatf("R1/R2/R3 sel=%0d div=%0d", selField, divField),
            n, int'(VECS[v][7:0]));
    end

    // R4: divider restart on field change
    selField = 2'b00; divField = 2'b10;
    repeat (21) @(negedge clk);
    divField = 2'b11;
    first = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (adcTickEn && first == 0) first = k;
    end
    check(first == 8, "R4 first pulse after change", first, 8);

    // R8: bus source releases convGo next cycle
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    check(convGo == 1'b1, "R8 bus convGo", convGo, 1);
    @(negedge clk);
    check(convGo == 1'b0, "R8 bus convGo single", convGo, 0);

    // R9: async selected, not requested
    selField = 2'b11; divField = 2'b00;
    countWin(n);
    check(n == 0 && !oscReq, "R9 no ticks while not ready", n, 0);

    // R6 R7 R8: on-demand oscillator
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    check(oscReq == 1'b1, "R6 request after start", oscReq, 1);
    ticks = 0; goSeen = 0;
    for (int k = 0; k < 60 && !oscReady; k++) begin
      if (convGo) goSeen = 1;
      if (oscTick) ticks++;
      @(negedge clk);
    end
    check(ticks == 8, "R7 startup ticks", ticks, 8);
    check(!goSeen && convGo, "R8 async convGo waits for ready", convGo, 1);
    divField = 2'b01;
    countWin(n);
    check(n == 32, "R1 async source divide 2", n, 32);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    check(oscReq == 1'b0, "R6 request drops after done", oscReq, 0);
    @(negedge clk);
    check(oscReady == 1'b0, "R7 ready drops", oscReady, 0);

    // R5: keep-alive
    oscEnable = 1'b1;
    @(negedge clk);
    check(oscReq == 1'b1, "R5 request on enable", oscReq, 1);
    repeat (30) @(negedge clk);
    check(oscReady == 1'b1, "R7 ready with enable", oscReady, 1);
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    check(convGo == 1'b1, "R8 convGo when already ready", convGo, 1);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    repeat (2) @(negedge clk);
    check(oscReq && oscReady, "R5 request held after done", {oscReq, oscReady}, 3);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule